// File: doc/BRIEF.md
# Gated Configuration Register Bank

This block holds a handful of host-visible configuration registers behind a plain register port. The port carries an index, 16-bit write data, a write strobe and a combinational 32-bit read value. One index returns a fixed compatibility constant. Another holds a control word whose bits do three things: they permit or block writes to four 16-bit LED programming registers, they permit or block writes to a 16-byte shadow memory, and they choose how the interrupt pin is driven.

The bank has two reset domains. A hard reset, asynchronous and active low, clears all storage. A soft reset or stop input leaves every stored bit alone. While it is held, it only forces the interrupt pin to its inactive level. The interrupt pin is presented as a drive value plus an output enable, so a board-level pull-up decides the level whenever the enable is off.

The register port is a control interface. A write completes on the rising clock edge where the strobe is high, and the port never back-pressures. Reads return the addressed value in the same cycle.

Top module: `cfg_bank_top`

## Requirements
- R1: Index 0 reads 0x0005, and writes to index 0 have no effect.
- R2: Bits 31-16 of every read are zero. Indices 2, 3 and 8-15 are unmapped: they read zero and writes to them change nothing.
- R3: The control word at index 1 stores only bit 14 (loopback pass), bit 12 (LED enable), bit 8 (shadow enable) and bit 7 (interrupt mode). Every other bit reads zero.
- R4: The LED registers sit at indices 4-7 and use 16 bits each. A write to them is stored only when control bit 12 is 1. When bit 12 is 0 the write is dropped.
- R5: The shadow memory sits at indices 16-31, with the byte address equal to index minus 16. A write stores write-data bits 7:0 only when control bit 8 is 1. Reads return the byte zero-extended, whatever bit 8 holds.
- R6: A change to an enable bit governs writes from the next write onward. A write issued in the cycle right after the enable is cleared is dropped.
- R7: With control bit 7 at 0, an active interrupt drives the pin low. An inactive one turns the output enable off, so the pulled-up pin reads 1.
- R8: With control bit 7 at 1, the output enable is always on. The pin drives 1 for an active interrupt and 0 for an inactive one.
- R9: Hard reset clears the control word, the LED registers and the shadow memory. Soft reset changes none of them.
- R10: While soft reset is high, the pin shows the inactive level of the current mode even if the interrupt request is high.
- R11: The loopback pass output is high only when control bit 14 is 1 and the twisted-pair select input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Soft reset / stop, active high |
| reg_idx | input | 5 | Register or shadow-byte index |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_idx |
| irq_req | input | 1 | Internal interrupt request |
| tp_sel | input | 1 | Twisted-pair interface selected |
| int_drv | output | 1 | Interrupt pin drive value |
| int_oe | output | 1 | Interrupt pin output enable |
| loop_pass | output | 1 | External loopback pass-through enable |

## Verification
The gating bits are the main risk. A wrong enable value shows up on the next LED or shadow write: a later read returns either the old value or the newly written one, when the other was expected. A corrupted mode bit shows within the same cycle on int_drv and int_oe, and the pulled-up pin level moves to the wrong polarity or floats. A soft reset that disturbs stored state appears on the first read-back after the reset is released.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int REG_W = 16;
  localparam int RD_W = 32;
  localparam logic [REG_W-1:0] COMPAT_VAL = 16'h0005;
  localparam int BIT_LOOP = 14;
  localparam int BIT_LEDEN = 12;
  localparam int BIT_RAMEN = 8;
  localparam int BIT_IMODE = 7;
  localparam logic [REG_W-1:0] CTRL_MASK =
    (REG_W'(1) << BIT_LOOP) | (REG_W'(1) << BIT_LEDEN) |
    (REG_W'(1) << BIT_RAMEN) | (REG_W'(1) << BIT_IMODE);
  localparam int IDX_COMPAT = 0;
  localparam int IDX_CTRL = 1;
  localparam int IDX_LED_BASE = 4;
endpackage

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfg_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_hard_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n) ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata & CTRL_MASK;
  end
endmodule

// File: rtl/cfg_led_regs.sv
module cfg_led_regs #(
  parameter int COUNT = 4,
  parameter int W = 16,
  parameter int OFF_W = 5
) (
  input  logic               clk,
  input  logic               rst_hard_n,
  input  logic               hit,
  input  logic               wr,
  input  logic               enable,
  input  logic [OFF_W-1:0]   off,
  input  logic [W-1:0]       wdata,
  output logic [COUNT*W-1:0] led_flat
);
  for (genvar i = 0; i < COUNT; i++) begin : g_led
    logic sel_wr;
    assign sel_wr = wr && hit && enable && (off == OFF_W'(i));
    always_ff @(posedge clk or negedge rst_hard_n) begin
      if (!rst_hard_n) led_flat[i*W +: W] <= '0;
      else if (sel_wr) led_flat[i*W +: W] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_shadow_ram.sv
module cfg_shadow_ram #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_hard_n,
  input  logic               wr,
  input  logic               enable,
  input  logic [AW-1:0]      addr,
  input  logic [W-1:0]       wdata,
  output logic [W-1:0]       rdata,
  output logic [DEPTH*W-1:0] mem_flat
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_hard_n) begin
      if (!rst_hard_n) mem_flat[i*W +: W] <= '0;
      else if (wr && enable && addr == AW'(i)) mem_flat[i*W +: W] <= wdata;
    end
  end
  assign rdata = mem_flat[addr*W +: W];
endmodule

// File: rtl/cfg_irq_pin.sv
module cfg_irq_pin (
  input  logic edge_mode,
  input  logic irq_req,
  input  logic quiesce,
  output logic drv,
  output logic oe
);
  logic active;
  assign active = irq_req && !quiesce;
  always_comb begin
    if (edge_mode) begin
      oe = 1'b1;
      drv = active;
    end else begin
      oe = active;
      drv = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_bank_top.sv
module cfg_bank_top
  import cfg_bank_pkg::*;
#(
  parameter int LED_COUNT = 4,
  parameter int RAM_DEPTH = 16,
  localparam int RAM_AW = $clog2(RAM_DEPTH),
  localparam int IDX_W = RAM_AW + 1
) (
  input  logic             clk,
  input  logic             rst_hard_n,
  input  logic             soft_rst,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_we,
  output logic [RD_W-1:0]  reg_rdata,
  input  logic             irq_req,
  input  logic             tp_sel,
  output logic             int_drv,
  output logic             int_oe,
  output logic             loop_pass
);
  localparam int BYTE_W = 8;

  logic [REG_W-1:0] ctrl_q;
  logic [LED_COUNT*REG_W-1:0] led_flat;
  logic [RAM_DEPTH*BYTE_W-1:0] ram_flat;
  logic [BYTE_W-1:0] ram_rd;
  logic [IDX_W-1:0] led_off;
  logic ram_hit, led_hit, ctrl_hit;
  logic [REG_W-1:0] rd16;

  assign ram_hit = reg_idx[IDX_W-1];
  assign led_off = reg_idx - IDX_W'(IDX_LED_BASE);
  assign led_hit = !ram_hit && (reg_idx >= IDX_W'(IDX_LED_BASE)) &&
                   (led_off < IDX_W'(LED_COUNT));
  assign ctrl_hit = (reg_idx == IDX_W'(IDX_CTRL));

  cfg_ctrl_reg u_ctrl (
    .clk(clk), .rst_hard_n(rst_hard_n),
    .wr(reg_we && ctrl_hit), .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  cfg_led_regs #(.COUNT(LED_COUNT), .W(REG_W), .OFF_W(IDX_W)) u_led (
    .clk(clk), .rst_hard_n(rst_hard_n), .hit(led_hit), .wr(reg_we),
    .enable(ctrl_q[BIT_LEDEN]), .off(led_off), .wdata(reg_wdata),
    .led_flat(led_flat)
  );

  cfg_shadow_ram #(.DEPTH(RAM_DEPTH), .W(BYTE_W)) u_ram (
    .clk(clk), .rst_hard_n(rst_hard_n), .wr(reg_we && ram_hit),
    .enable(ctrl_q[BIT_RAMEN]), .addr(reg_idx[RAM_AW-1:0]),
    .wdata(reg_wdata[BYTE_W-1:0]), .rdata(ram_rd), .mem_flat(ram_flat)
  );

  cfg_irq_pin u_irq (
    .edge_mode(ctrl_q[BIT_IMODE]), .irq_req(irq_req), .quiesce(soft_rst),
    .drv(int_drv), .oe(int_oe)
  );

  assign loop_pass = ctrl_q[BIT_LOOP] && tp_sel;

  always_comb begin
    rd16 = '0;
    if (ram_hit) rd16 = {{(REG_W-BYTE_W){1'b0}}, ram_rd};
    else if (reg_idx == IDX_W'(IDX_COMPAT)) rd16 = COMPAT_VAL;
    else if (ctrl_hit) rd16 = ctrl_q;
    else if (led_hit) begin
      for (int i = 0; i < LED_COUNT; i++)
        if (led_off == IDX_W'(i)) rd16 = led_flat[i*REG_W +: REG_W];
    end
  end
  assign reg_rdata = {{(RD_W-REG_W){1'b0}}, rd16};
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
  parameter int IDX_W = 5,
  parameter int LED_BITS = 64,
  parameter int RAM_BITS = 128
) (
  input logic                clk,
  input logic                rst_hard_n,
  input logic                soft_rst,
  input logic                reg_we,
  input logic [IDX_W-1:0]    reg_idx,
  input logic [15:0]         ctrl_q,
  input logic [LED_BITS-1:0] led_flat,
  input logic [RAM_BITS-1:0] ram_flat,
  input logic                int_drv,
  input logic                int_oe
);
  logic pin_lvl;
  logic led_idx;
  assign pin_lvl = int_oe ? int_drv : 1'b1;
  assign led_idx = !reg_idx[IDX_W-1] && (reg_idx[IDX_W-2:0] >= (IDX_W-1)'(4)) &&
                   (reg_idx[IDX_W-2:0] < (IDX_W-1)'(8));

  assert_ctrl_reserved_R3: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (ctrl_q & ~16'h5180) == 16'h0000);

  assert_led_gated_R4: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (reg_we && led_idx && !ctrl_q[12]) |=> $stable(led_flat));

  assert_ram_gated_R5: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (reg_we && reg_idx[IDX_W-1] && !ctrl_q[8]) |=> $stable(ram_flat));

  assert_level_never_high_R7: assert property (@(posedge clk) disable iff (!rst_hard_n)
    !ctrl_q[7] |-> !(int_oe && int_drv));

  assert_edge_always_driven_R8: assert property (@(posedge clk) disable iff (!rst_hard_n)
    ctrl_q[7] |-> int_oe);

  assert_soft_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_hard_n)
    (soft_rst && !reg_we) |=> ($stable(ctrl_q) && $stable(led_flat) && $stable(ram_flat)));

  assert_soft_quiets_pin_R10: assert property (@(posedge clk) disable iff (!rst_hard_n)
    soft_rst |-> (pin_lvl == !ctrl_q[7]));
endmodule

bind cfg_bank_top cfg_bank_chk #(
  .IDX_W(IDX_W), .LED_BITS(LED_COUNT*16), .RAM_BITS(RAM_DEPTH*8)
) u_chk (
  .clk(clk), .rst_hard_n(rst_hard_n), .soft_rst(soft_rst), .reg_we(reg_we),
  .reg_idx(reg_idx), .ctrl_q(ctrl_q), .led_flat(led_flat), .ram_flat(ram_flat),
  .int_drv(int_drv), .int_oe(int_oe)
);

// File: tb/test_cfg_bank_top.sv
module test_cfg_bank_top;
  logic clk = 1'b0;
  logic rst_hard_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [4:0] reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic irq_req = 1'b0;
  logic tp_sel = 1'b0;
  logic int_drv, int_oe, loop_pass;
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_bank_top i_cfg_bank_top (
    .clk(clk), .rst_hard_n(rst_hard_n), .soft_rst(soft_rst), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .tp_sel(tp_sel), .int_drv(int_drv), .int_oe(int_oe),
    .loop_pass(loop_pass)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] idx, logic [31:0] exp);
    reg_idx = idx;
    #2;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic pin();
    return int_oe ? int_drv : 1'b1;
  endfunction

  task automatic t_reset;
    rd_chk("R1 reset const", 5'd0, 32'h5);
    rd_chk("R9 reset ctrl", 5'd1, 32'h0);
    rd_chk("R9 reset led", 5'd6, 32'h0);
    rd_chk("R9 reset ram", 5'd20, 32'h0);
    #1 chk("R7 reset pin oe", {31'b0, int_oe}, 32'h0);
  endtask

  task automatic t_compat;
    wr(5'd0, 16'hFFFF);
    rd_chk("R1 const after write", 5'd0, 32'h5);
  endtask

  task automatic t_ctrl;
    wr(5'd1, 16'hFFFF);
    rd_chk("R3 ctrl writable bits", 5'd1, 32'h5180);
    wr(5'd1, 16'h0000);
    rd_chk("R3 ctrl cleared", 5'd1, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(5'd2, 16'hABCD);
    rd_chk("R2 unmapped idx2", 5'd2, 32'h0);
    wr(5'd9, 16'h1234);
    rd_chk("R2 unmapped idx9", 5'd9, 32'h0);
  endtask

  task automatic t_led;
    wr(5'd1, 16'h0000);
    wr(5'd6, 16'h1234);
    rd_chk("R4 led write blocked", 5'd6, 32'h0);
    wr(5'd1, 16'h1000);
    wr(5'd6, 16'h1234);
    rd_chk("R4 led write accepted", 5'd6, 32'h1234);
    wr(5'd4, 16'hBEEF);
    rd_chk("R4 led0 accepted", 5'd4, 32'hBEEF);
    rd_chk("R2 led upper zero", 5'd6, 32'h1234);
    wr(5'd1, 16'h0000);
    wr(5'd6, 16'hAAAA);
    rd_chk("R6 write after disable dropped", 5'd6, 32'h1234);
  endtask

  task automatic t_ram;
    wr(5'd1, 16'h0000);
    wr(5'd19, 16'h005A);
    rd_chk("R5 ram write blocked", 5'd19, 32'h0);
    wr(5'd1, 16'h0100);
    wr(5'd19, 16'h005A);
    rd_chk("R6 ram enabled next write", 5'd19, 32'h5A);
    wr(5'd31, 16'hFFC3);
    rd_chk("R5 ram byte only", 5'd31, 32'hC3);
    wr(5'd1, 16'h0000);
    wr(5'd31, 16'h0011);
    rd_chk("R5 ram read while disabled", 5'd31, 32'hC3);
    rd_chk("R5 ram other byte", 5'd19, 32'h5A);
  endtask

  task automatic t_irq;
    wr(5'd1, 16'h0000);
    irq_req = 1'b1; #2;
    chk("R7 level active pin", {31'b0, pin()}, 32'h0);
    chk("R7 level active oe", {31'b0, int_oe}, 32'h1);
    irq_req = 1'b0; #2;
    chk("R7 level inactive oe", {31'b0, int_oe}, 32'h0);
    chk("R7 level inactive pin", {31'b0, pin()}, 32'h1);
    wr(5'd1, 16'h0080);
    irq_req = 1'b1; #2;
    chk("R8 edge active pin", {31'b0, pin()}, 32'h1);
    irq_req = 1'b0; #2;
    chk("R8 edge inactive oe", {31'b0, int_oe}, 32'h1);
    chk("R8 edge inactive pin", {31'b0, pin()}, 32'h0);
  endtask

  task automatic t_soft;
    wr(5'd1, 16'h5180);
    wr(5'd5, 16'h7777);
    wr(5'd17, 16'h0099);
    @(negedge clk);
    irq_req = 1'b1; soft_rst = 1'b1; #2;
    chk("R10 soft edge mode pin", {31'b0, pin()}, 32'h0);
    repeat (3) @(negedge clk);
    soft_rst = 1'b0;
    rd_chk("R9 soft keeps ctrl", 5'd1, 32'h5180);
    rd_chk("R9 soft keeps led", 5'd5, 32'h7777);
    rd_chk("R9 soft keeps ram", 5'd17, 32'h99);
    chk("R10 pin back active", {31'b0, pin()}, 32'h1);
    wr(5'd1, 16'h0000);
    soft_rst = 1'b1; #2;
    chk("R10 soft level mode pin", {31'b0, pin()}, 32'h1);
    @(negedge clk);
    soft_rst = 1'b0; irq_req = 1'b0;
  endtask

  task automatic t_loop;
    wr(5'd1, 16'h4000);
    tp_sel = 1'b0; #2;
    chk("R11 loop without tp", {31'b0, loop_pass}, 32'h0);
    tp_sel = 1'b1; #2;
    chk("R11 loop with tp", {31'b0, loop_pass}, 32'h1);
    wr(5'd1, 16'h0000);
    #2 chk("R11 loop bit cleared", {31'b0, loop_pass}, 32'h0);
    tp_sel = 1'b0;
  endtask

  task automatic t_hard;
    wr(5'd1, 16'h5180);
    wr(5'd7, 16'h4242);
    wr(5'd16, 16'h0033);
    @(negedge clk);
    rst_hard_n = 1'b0;
    @(negedge clk);
    rst_hard_n = 1'b1;
    rd_chk("R9 hard clears ctrl", 5'd1, 32'h0);
    rd_chk("R9 hard clears led", 5'd7, 32'h0);
    rd_chk("R9 hard clears ram", 5'd16, 32'h0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_hard_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compat();
    t_ctrl();
    t_unmapped();
    t_led();
    t_ram();
    t_irq();
    t_soft();
    t_loop();
    t_hard();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule